// File: doc/BRIEF.md
# Time Base and Real-Time Clock Interrupt Divider

This block divides a slow reference clock through one shared binary counter and derives two periodic time-out events from it. The time-base event has a period fixed when the block is built, chosen among four power-of-two divisors by a parameter. The real-time-clock event has a period chosen while running, through a 3-bit select input that picks one of eight power-of-two divisors.

Each time-out is a one-cycle pulse. It also sets a sticky pending flag that serves as the interrupt request for that source. Software clears a flag with a write strobe whose data carries a one at the flag's bit position in the interrupt control word. The real-time-clock pulse is also meant as a clock enable for a downstream timer/event counter, so that longer periods can be built. A core halt input is accepted, and the divider keeps running through it.

Top module: `tbrtc_timer`

## Requirements
- R1: While reset is asserted and right after it, `tb_tick`, `rtc_tick`, `tb_pend` and `rtc_pend` are all 0.
- R2: `tb_tick` pulses once every 2^(12+TB_SEL) clock cycles, with TB_SEL a build parameter in 0..3 (default 0, period 4096).
- R3: `rtc_tick` pulses once every 2^(8+rt_sel) cycles: 3'b000 gives 256 and each increment doubles the period, up to 3'b111 giving 32768.
- R4: Each `tb_tick` and `rtc_tick` pulse lasts exactly one clock cycle.
- R5: `tb_pend` goes to 1 in the same cycle as a `tb_tick` pulse and stays 1 until it is cleared.
- R6: `rtc_pend` goes to 1 in the same cycle as an `rtc_tick` pulse and stays 1 until it is cleared. It never rises without a pulse.
- R7: A cycle with `clr_stb`=1 clears `tb_pend` if `clr_data[5]`=1 and clears `rtc_pend` if `clr_data[6]`=1, visible the next cycle. A flag whose bit is 0 is left unchanged, and all other data bits are ignored.
- R8: If a flag is set and cleared in the same cycle, the set wins and the flag stays 1.
- R9: A change of `rt_sel` does not restart the divider. The new divisor applies at the next transition of its counter bit, so with 3'b000 selected the next pulse comes 128 counts after the counter's low eight bits were zero.
- R10: `core_halt` has no effect on the pulse periods or on the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow reference clock fS |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| core_halt | input | 1 | Core halt indication; the divider keeps running |
| rt_sel | input | 3 | Real-time-clock divisor select, period 2^(8+rt_sel) |
| clr_stb | input | 1 | Flag clear write strobe |
| clr_data | input | 8 | Clear data: bit 5 clears the time-base flag, bit 6 the real-time-clock flag |
| tb_tick | output | 1 | One-cycle time-base time-out pulse |
| rtc_tick | output | 1 | One-cycle real-time-clock time-out pulse, also a timer clock enable |
| tb_pend | output | 1 | Sticky time-base interrupt request |
| rtc_pend | output | 1 | Sticky real-time-clock interrupt request |

## Verification
A flag set from a time-out and a software clear of the same flag can fall in one cycle. The bench aligns to an observed real-time-clock pulse, counts off one full period less one cycle, and then drives the clear strobe so that it meets the next set at the same edge. It judges the outcome by seeing the pulse and a still-set flag in that cycle, and then a clean clear one cycle later. A second overlap, a select change in the middle of a period, is judged by the exact cycle distance to the next pulse, which shows that the counter was not restarted.

// File: rtl/tbrtc_pkg.sv
package tbrtc_pkg;
  localparam int unsigned CNT_W   = 15;  // longest divisor is 2^15
  localparam int unsigned RT_BASE = 8;   // rt_sel 0 -> 2^8
  localparam int unsigned TB_BASE = 12;  // TB_SEL 0 -> 2^12
  localparam int unsigned FLAG_W  = 8;   // interrupt control word width
  localparam int unsigned TB_BIT  = 5;   // time-base flag position
  localparam int unsigned RTC_BIT = 6;   // real-time-clock flag position

  // True when counter value v has just made bit k-1 rise,
  // i.e. its low k bits equal 2^(k-1).
  function automatic logic tap_hit(input logic [CNT_W-1:0] v, input int unsigned k);
    logic [CNT_W-1:0] msk;
    logic [CNT_W-1:0] hit;
    msk = CNT_W'((32'd1 << k) - 32'd1);
    hit = CNT_W'(32'd1 << (k - 1));
    return (v & msk) == hit;
  endfunction
endpackage

// File: rtl/tbrtc_rst_sync.sv
module tbrtc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tbrtc_prescaler.sv
module tbrtc_prescaler import tbrtc_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_nxt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_nxt = cnt_d;
endmodule

// File: rtl/tbrtc_tap.sv
module tbrtc_tap import tbrtc_pkg::*; #(
  parameter int unsigned SEL_W   = 3,
  parameter bit          RUNTIME = 1'b0,
  parameter int unsigned BASE_K  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic hit_d;
  logic tick_q;

  generate
    if (RUNTIME) begin : g_runtime
      always_comb begin
        hit_d = tap_hit(cnt_nxt, BASE_K + int'(sel));
      end
    end else begin : g_fixed
      logic sel_unused;
      assign sel_unused = ^sel;
      always_comb begin
        hit_d = tap_hit(cnt_nxt, BASE_K);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= hit_d;
  end

  assign tick = tick_q;
endmodule

// File: rtl/tbrtc_flag.sv
module tbrtc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;
  logic pend_d;

  always_comb begin
    pend_d = set_i | (pend_q & ~clr_i);  // set has priority
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/tbrtc_timer.sv
module tbrtc_timer import tbrtc_pkg::*; #(
  parameter int unsigned TB_SEL = 0,
  parameter int unsigned SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_halt,
  input  logic [SEL_W-1:0]  rt_sel,
  input  logic              clr_stb,
  input  logic [FLAG_W-1:0] clr_data,
  output logic              tb_tick,
  output logic              rtc_tick,
  output logic              tb_pend,
  output logic              rtc_pend
);
  localparam int unsigned TB_K  = TB_BASE + TB_SEL;
  localparam int unsigned N_SRC = 2;

  logic             rst_i_n;
  logic [CNT_W-1:0] cnt_nxt;
  logic [N_SRC-1:0] set_v;
  logic [N_SRC-1:0] clr_v;
  logic [N_SRC-1:0] pend_v;
  logic             halt_unused;

  // The divider is not gated by the halt input.
  assign halt_unused = core_halt ^ (^clr_data);

  tbrtc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  tbrtc_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .cnt_nxt (cnt_nxt)
  );

  tbrtc_tap #(.SEL_W(SEL_W), .RUNTIME(1'b0), .BASE_K(TB_K)) u_tb_tap (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .cnt_nxt (cnt_nxt),
    .sel     ('0),
    .tick    (tb_tick)
  );

  tbrtc_tap #(.SEL_W(SEL_W), .RUNTIME(1'b1), .BASE_K(RT_BASE)) u_rtc_tap (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .cnt_nxt (cnt_nxt),
    .sel     (rt_sel),
    .tick    (rtc_tick)
  );

  // The flags share the edge with the tick registers, so each flag
  // is set from the same hit that sets its tick.
  logic tb_hit_d;
  logic rtc_hit_d;
  always_comb begin
    tb_hit_d  = tap_hit(cnt_nxt, TB_K);
    rtc_hit_d = tap_hit(cnt_nxt, RT_BASE + int'(rt_sel));
    set_v     = {rtc_hit_d, tb_hit_d};
    clr_v     = {clr_stb & clr_data[RTC_BIT], clr_stb & clr_data[TB_BIT]};
  end

  generate
    for (genvar g = 0; g < N_SRC; g++) begin : g_flag
      tbrtc_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_i_n),
        .set_i  (set_v[g]),
        .clr_i  (clr_v[g]),
        .pend_o (pend_v[g])
      );
    end
  endgenerate

  assign tb_pend  = pend_v[0];
  assign rtc_pend = pend_v[1];
endmodule

// File: rtl/tbrtc_timer_chk.sv
module tbrtc_timer_chk import tbrtc_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_stb,
  input logic [FLAG_W-1:0] clr_data,
  input logic              tb_tick,
  input logic              rtc_tick,
  input logic              tb_pend,
  input logic              rtc_pend
);
  p_rtc_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_tick |=> !rtc_tick);
  p_tb_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tb_tick |=> !tb_tick);
  p_tb_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tb_tick |-> tb_pend);
  p_rtc_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_tick |-> rtc_pend);
  p_rtc_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rtc_pend) |-> rtc_tick);
  p_rtc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_pend && !(clr_stb && clr_data[RTC_BIT])) |=> rtc_pend);
  p_rtc_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rtc_pend) |-> $past(clr_stb && clr_data[RTC_BIT]));
  p_tb_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tb_pend) |-> $past(clr_stb && clr_data[TB_BIT]));
endmodule

bind tbrtc_timer tbrtc_timer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_stb  (clr_stb),
  .clr_data (clr_data),
  .tb_tick  (tb_tick),
  .rtc_tick (rtc_tick),
  .tb_pend  (tb_pend),
  .rtc_pend (rtc_pend)
);

// File: tb/sim_tbrtc_timer.sv
`timescale 1ns/1ps
module sim_tbrtc_timer;
  localparam int unsigned TBS = 0;
  localparam int TB_PERIOD = 1 << (12 + TBS);

  logic       clk = 1'b0;
  logic       rst_n;
  logic       core_halt;
  logic [2:0] rt_sel;
  logic       clr_stb;
  logic [7:0] clr_data;
  logic       tb_tick, rtc_tick, tb_pend, rtc_pend;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  tbrtc_timer #(.TB_SEL(TBS)) u0 (
    .clk(clk), .rst_n(rst_n), .core_halt(core_halt), .rt_sel(rt_sel),
    .clr_stb(clr_stb), .clr_data(clr_data),
    .tb_tick(tb_tick), .rtc_tick(rtc_tick), .tb_pend(tb_pend), .rtc_pend(rtc_pend)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sync_rtc();
    int guard = 0;
    do begin @(negedge clk); guard++; end while (!rtc_tick && guard < 70000);
  endtask

  task automatic sync_tb();
    int guard = 0;
    do begin @(negedge clk); guard++; end while (!tb_tick && guard < 70000);
  endtask

  // R3 / R6: period of rtc_tick for one select value
  task automatic t_rtc_period(input logic [2:0] sel, input string tag);
    int n = 0;
    @(negedge clk); rt_sel = sel;
    sync_rtc();
    chk(rtc_pend == 1'b1, {tag, " R6 pend with tick"}, rtc_pend, 1);
    do begin @(negedge clk); n++; end while (!rtc_tick && n < 70000);
    chk(n == (1 << (8 + sel)), {tag, " R3 rtc period"}, n, 1 << (8 + sel));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; core_halt = 1'b0; rt_sel = 3'd0; clr_stb = 1'b0; clr_data = 8'h00;
    repeat (4) @(negedge clk);
    chk({tb_tick, rtc_tick, tb_pend, rtc_pend} == 4'b0, "R1 in reset",
        {tb_tick, rtc_tick, tb_pend, rtc_pend}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({tb_tick, rtc_tick, tb_pend, rtc_pend} == 4'b0, "R1 after release",
        {tb_tick, rtc_tick, tb_pend, rtc_pend}, 0);
  endtask

  task automatic t_pulse();
    @(negedge clk); rt_sel = 3'd0;
    sync_rtc();
    @(negedge clk);
    chk(rtc_tick == 1'b0, "R4 rtc pulse one cycle", rtc_tick, 0);
    sync_tb();
    @(negedge clk);
    chk(tb_tick == 1'b0, "R4 tb pulse one cycle", tb_tick, 0);
  endtask

  task automatic t_clear_rtc();
    logic tb_before;
    rt_sel = 3'd0;
    sync_rtc();
    tb_before = tb_pend;
    clr_stb = 1'b1; clr_data = 8'h9F;       // bits 5 and 6 are zero
    @(negedge clk);
    clr_stb = 1'b0;
    chk(rtc_pend == 1'b1, "R7 other bits ignored (rtc)", rtc_pend, 1);
    chk(tb_pend == tb_before, "R7 other bits ignored (tb)", tb_pend, tb_before);
    clr_stb = 1'b1; clr_data = 8'h40;
    @(negedge clk);
    clr_stb = 1'b0; clr_data = 8'h00;
    chk(rtc_pend == 1'b0, "R7 bit6 clears rtc_pend", rtc_pend, 0);
    chk(tb_pend == tb_before, "R7 bit6 leaves tb_pend", tb_pend, tb_before);
    repeat (20) @(negedge clk);
    chk(rtc_pend == 1'b0, "R6 stays clear without tick", rtc_pend, 0);
  endtask

  task automatic t_tb();
    int n = 0;
    sync_tb();
    chk(tb_pend == 1'b1, "R5 tb_pend with tick", tb_pend, 1);
    do begin @(negedge clk); n++; end while (!tb_tick && n < 70000);
    chk(n == TB_PERIOD, "R2 tb period", n, TB_PERIOD);
    repeat (10) @(negedge clk);
    chk(tb_pend == 1'b1, "R5 tb_pend sticky", tb_pend, 1);
    clr_stb = 1'b1; clr_data = 8'h20;
    @(negedge clk);
    clr_stb = 1'b0; clr_data = 8'h00;
    chk(tb_pend == 1'b0, "R7 bit5 clears tb_pend", tb_pend, 0);
  endtask

  task automatic t_collide();
    rt_sel = 3'd0;
    sync_rtc();
    repeat (255) @(negedge clk);
    clr_stb = 1'b1; clr_data = 8'h40;
    @(negedge clk);
    chk(rtc_tick == 1'b1, "R8 tick in collision cycle", rtc_tick, 1);
    chk(rtc_pend == 1'b1, "R8 set wins over clear", rtc_pend, 1);
    @(negedge clk);
    clr_stb = 1'b0; clr_data = 8'h00;
    chk(rtc_pend == 1'b0, "R7 clear after collision", rtc_pend, 0);
  endtask

  task automatic t_resel();
    int n = 0;
    @(negedge clk); rt_sel = 3'd3;
    sync_rtc();
    sync_rtc();
    do begin
      @(negedge clk); n++;
      if (n == 100) rt_sel = 3'd0;
    end while (!rtc_tick && n < 5000);
    chk(n == 128, "R9 select change keeps chain", n, 128);
  endtask

  task automatic t_halt();
    core_halt = 1'b1;
    t_rtc_period(3'd0, "halt");
    t_rtc_period(3'd2, "halt");
    chk(rtc_pend == 1'b1, "R10 flag set under halt", rtc_pend, 1);
    core_halt = 1'b0;
    chk(1'b1, "R10 halt sequence done", 1, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_rtc_period(3'd0, "sel0");
    t_rtc_period(3'd1, "sel1");
    t_rtc_period(3'd2, "sel2");
    t_rtc_period(3'd3, "sel3");
    t_rtc_period(3'd5, "sel5");
    t_rtc_period(3'd7, "sel7");
    t_pulse();
    t_clear_rtc();
    t_tb();
    t_collide();
    t_resel();
    t_halt();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule